// File: doc/BRIEF.md
# Serial Flash Erase Command Controller

This block is the command side of a serial flash device. It watches a serial port with a serial clock, an active-low chip select and a single data input, decodes four byte-wide commands, and keeps a small status word. The status word holds the write-enable latch, the erase-busy flag and four protect bits. The serial pins are sampled in the system clock domain. Edges of the serial clock and of chip select are detected there, so the serial clock must run well below the system clock.

An erase command is committed only when chip select returns high exactly on the bit count that closes the command. The latch must be set, no protect bit may be set, and no erase may be running. When those hold, the block sends a one-cycle request to the array port, either for the whole array or for one sector address. It then stays busy for a fixed number of system clock cycles. The latch is cleared when that busy period starts. The status byte can be read at any time, including during the busy period, and it repeats for as long as chip select stays low.

Top module: `flash_erase_ctrl`

## Requirements
- R1: A write-enable frame (opcode 06h, exactly 8 bits, MSB first) sets the write-enable latch, seen as status bit 1.
- R2: A bulk-erase frame (opcode C7h, exactly 8 bits) with the latch set and all protect bits clear raises `er_req` for exactly one system clock cycle with `er_all` = 1.
- R3: A sector-erase frame (opcode D8h followed by an ADDR_W-bit address MSB first, exactly 8+ADDR_W bits) that passes the same gates raises `er_req` for one cycle with `er_all` = 0 and `er_addr` equal to the shifted address.
- R4: When chip select rises at any bit count other than the one that closes the command, the frame is discarded: no latch change and no request.
- R5: Neither erase command issues a request while the write-enable latch is clear.
- R6: If any bit of `prot_bits` is 1, both erase commands are ignored and the latch keeps its value. The protect bits appear in status bits 5:2.
- R7: An accepted erase clears the latch and sets the busy flag (status bit 0) in the cycle that the request is issued. The busy flag returns to 0 after ERASE_CYCLES system clock cycles.
- R8: A read-status frame (opcode 05h) drives the live status byte on `spi_miso`, MSB first, starting after the 8th opcode bit. The byte repeats while chip select stays low, with bits 7:6 = 0. `spi_miso` is 0 outside a status read.
- R9: While the busy flag is 1, every command except read-status is ignored.
- R10: After reset the latch and busy flag are 0, `er_req` is 0 and `spi_miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock; data sampled on its rising edge |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out (status byte) |
| prot_bits | input | 4 | Block-protect bits |
| er_req | output | 1 | One-cycle erase request to the array |
| er_all | output | 1 | 1 = whole array, 0 = one sector |
| er_addr | output | ADDR_W | Sector address for a sector erase |

## Verification
Two things can happen in the same cycle: the end of the self-timed busy period and a status byte being shifted out. The bench keeps chip select low after a read-status opcode and reads byte after byte while an erase counts down. The busy period ends partway through this stream. Each byte must show the latch clear, and the busy bit must read 1 in the first byte and 0 in a later byte of the same frame. That shows the status mux follows the live flag rather than a copy taken at the opcode.

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl #(
  parameter int ADDR_W       = 24,
  parameter int ERASE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [3:0]        prot_bits,
  output logic              er_req,
  output logic              er_all,
  output logic [ADDR_W-1:0] er_addr
);
  localparam int FRAME = 8 + ADDR_W;
  localparam int CW    = $clog2(FRAME + 2);
  localparam int TW    = $clog2(ERASE_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = '1;
  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_BULK = 8'hC7;
  localparam logic [7:0] OP_SECT = 8'hD8;
  localparam logic [7:0] OP_STAT = 8'h05;

  logic sck_q, sck_d, cs_q, cs_d, mosi_q;
  logic [FRAME-1:0] sr;
  logic [CW-1:0]    cnt;
  logic [TW-1:0]    timer;
  logic             wel, wip, rd_mode;
  logic [2:0]       rd_idx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= 1'b0; sck_d <= 1'b0; cs_q <= 1'b1; cs_d <= 1'b1; mosi_q <= 1'b0;
    end else begin
      sck_q <= spi_sck; sck_d <= sck_q; cs_q <= spi_cs_n; cs_d <= cs_q; mosi_q <= spi_mosi;
    end

  wire sck_rise = sck_q & ~sck_d;
  wire cs_rise  = cs_q & ~cs_d;
  wire shift_en = sck_rise & ~cs_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (cs_q) begin
      cnt <= '0;
    end else if (shift_en) begin
      sr <= {sr[FRAME-2:0], mosi_q};
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

  wire ok_erase = wel && !wip && (prot_bits == 4'b0);
  wire do_wen   = cs_rise && cnt == CW'(8) && sr[7:0] == OP_WEN && !wip;
  wire do_bulk  = cs_rise && cnt == CW'(8) && sr[7:0] == OP_BULK && ok_erase;
  wire do_sect  = cs_rise && cnt == CW'(FRAME) && sr[FRAME-1 -: 8] == OP_SECT && ok_erase;
  wire start    = do_bulk | do_sect;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wel <= 1'b0; wip <= 1'b0; timer <= '0;
      er_req <= 1'b0; er_all <= 1'b0; er_addr <= '0;
    end else begin
      er_req <= start;
      if (start) begin
        wel     <= 1'b0;
        wip     <= 1'b1;
        timer   <= TW'(ERASE_CYCLES - 1);
        er_all  <= do_bulk;
        er_addr <= do_sect ? sr[ADDR_W-1:0] : '0;
      end else begin
        if (do_wen) wel <= 1'b1;
        if (wip) begin
          if (timer == '0) wip <= 1'b0;
          else timer <= timer - 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_mode <= 1'b0; rd_idx <= '0;
    end else if (cs_q) begin
      rd_mode <= 1'b0; rd_idx <= '0;
    end else if (shift_en) begin
      if (rd_mode) rd_idx <= rd_idx + 1'b1;
      else if (cnt == CW'(7) && {sr[6:0], mosi_q} == OP_STAT) rd_mode <= 1'b1;
    end

  wire [7:0] status = {2'b00, prot_bits, wel, wip};
  assign spi_miso = rd_mode & status[3'd7 - rd_idx];
endmodule

module fec_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       er_req,
  input logic       wel,
  input logic       wip,
  input logic [3:0] prot_bits,
  input logic       spi_cs_n,
  input logic       spi_miso
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) er_req |=> !er_req); // R2
  AST_REQ_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n) er_req |-> $past(wel)); // R5
  AST_REQ_UNPROT: assert property (@(posedge clk) disable iff (!rst_n) er_req |-> $past(prot_bits) == 4'b0); // R6
  AST_REQ_BUSY_NO_WEL: assert property (@(posedge clk) disable iff (!rst_n) er_req |-> (wip && !wel)); // R7
  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) er_req |-> !$past(wip)); // R9
  AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $past(spi_cs_n) && spi_cs_n |=> !spi_miso); // R8
endmodule

bind flash_erase_ctrl fec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .er_req(er_req), .wel(wel), .wip(wip),
  .prot_bits(prot_bits), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
);

// File: tb/flash_erase_ctrl_bench.sv
module flash_erase_ctrl_bench;
  localparam int ADDR_W = 24;
  localparam int ECYC   = 1000;
  localparam int HALF   = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic [3:0] prot_bits = 4'b0;
  logic spi_miso, er_req, er_all;
  logic [ADDR_W-1:0] er_addr;

  int checks = 0, fails = 0, req_cnt = 0;
  logic last_all;
  logic [ADDR_W-1:0] last_addr;

  always #4 clk = ~clk;

  flash_erase_ctrl #(.ADDR_W(ADDR_W), .ERASE_CYCLES(ECYC)) u_flash_erase_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .prot_bits(prot_bits), .er_req(er_req), .er_all(er_all), .er_addr(er_addr)
  );

  always @(negedge clk)
    if (er_req) begin
      req_cnt++;
      last_all  = er_all;
      last_addr = er_addr;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      spi_mosi = v[i];
      clks(HALF); spi_sck = 1'b1;
      clks(HALF); spi_sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [63:0] v, input int n);
    spi_cs_n = 1'b0; clks(HALF);
    send_bits(v, n);
    clks(HALF); spi_cs_n = 1'b1; clks(8);
  endtask

  task automatic get_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      clks(HALF); b[i] = spi_miso;
      spi_sck = 1'b1; clks(HALF); spi_sck = 1'b0;
    end
  endtask

  task automatic read_status(output logic [7:0] b);
    spi_cs_n = 1'b0; clks(HALF);
    send_bits(64'h05, 8);
    get_byte(b);
    clks(HALF); spi_cs_n = 1'b1; clks(8);
  endtask

  task automatic t_reset;
    logic [7:0] s;
    chk("R10 er_req", {31'b0, er_req}, 32'h0);
    chk("R10 miso", {31'b0, spi_miso}, 32'h0);
    prot_bits = 4'b1010;
    read_status(s);
    chk("R10/R8 status after reset", {24'b0, s}, 32'h28);
    prot_bits = 4'b0;
    chk("R8 miso idle after read", {31'b0, spi_miso}, 32'h0);
  endtask

  task automatic t_no_wel;
    logic [7:0] s;
    int n0 = req_cnt;
    frame(64'hC7, 8);
    frame(64'hD8000100, 32);
    chk("R5 erase without latch", req_cnt, n0);
    read_status(s);
    chk("R5 still idle", {24'b0, s}, 32'h00);
  endtask

  task automatic t_wen;
    logic [7:0] s;
    frame(64'h03, 7);
    read_status(s);
    chk("R4 short write-enable", {31'b0, s[1]}, 32'h0);
    frame(64'h0C, 9);
    read_status(s);
    chk("R4 long write-enable", {31'b0, s[1]}, 32'h0);
    frame(64'h06, 8);
    read_status(s);
    chk("R1 latch set", {24'b0, s}, 32'h02);
  endtask

  task automatic t_bulk;
    logic [7:0] s;
    int n0 = req_cnt;
    frame(64'h18E, 9);
    chk("R4 bulk at 9 bits", req_cnt, n0);
    read_status(s);
    chk("R4 latch kept", {31'b0, s[1]}, 32'h1);
    frame(64'hC7, 8);
    chk("R2 one request", req_cnt, n0 + 1);
    chk("R2 whole-array flag", {31'b0, last_all}, 32'h1);
    read_status(s);
    chk("R7 busy set, latch cleared", {24'b0, s}, 32'h01);
    frame(64'h06, 8);
    read_status(s);
    chk("R9 write-enable ignored while busy", {24'b0, s}, 32'h01);
    frame(64'hC7, 8);
    chk("R9 no request while busy", req_cnt, n0 + 1);
    clks(ECYC - 700);
    read_status(s);
    chk("R7 still busy before end", {31'b0, s[0]}, 32'h1);
    clks(400);
    read_status(s);
    chk("R7 busy cleared", {24'b0, s}, 32'h00);
  endtask

  task automatic t_protect;
    logic [7:0] s;
    int n0 = req_cnt;
    prot_bits = 4'b0100;
    frame(64'h06, 8);
    frame(64'hC7, 8);
    frame(64'hD8123456, 32);
    chk("R6 protected erase ignored", req_cnt, n0);
    read_status(s);
    chk("R6 status with protect", {24'b0, s}, 32'h12);
    prot_bits = 4'b0;
  endtask

  task automatic t_sector;
    logic [7:0] s;
    int n0 = req_cnt;
    frame(64'hD8A53C0F, 31);
    frame(64'h1B14A781F, 33);
    chk("R4 sector bad length", req_cnt, n0);
    frame(64'hD8A53C0F, 32);
    chk("R3 one request", req_cnt, n0 + 1);
    chk("R3 sector flag", {31'b0, last_all}, 32'h0);
    chk("R3 address", {8'b0, last_addr}, 32'h00A53C0F);
    read_status(s);
    chk("R7 sector busy", {24'b0, s}, 32'h01);
    clks(ECYC + 100);
  endtask

  task automatic t_poll;
    logic [7:0] b, first;
    int n;
    frame(64'h06, 8);
    frame(64'hC7, 8);
    spi_cs_n = 1'b0; clks(HALF);
    send_bits(64'h05, 8);
    get_byte(first);
    chk("R8 first polled byte", {24'b0, first}, 32'h01);
    b = first; n = 0;
    while (b[0] && n < 40) begin
      get_byte(b);
      if (b[1]) chk("R7 latch stays clear", {31'b0, b[1]}, 32'h0);
      n++;
    end
    chk("R8 busy cleared within frame", {24'b0, b}, 32'h00);
    clks(HALF); spi_cs_n = 1'b1; clks(8);
  endtask

  initial begin
    clks(5); rst_n = 1'b1; clks(5);
    t_reset;
    t_no_wel;
    t_wen;
    t_bulk;
    t_protect;
    t_sector;
    t_poll;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule